// File: doc/BRIEF.md
# Communication Controller Interrupt Aggregator

This block gathers the event pulses of a time-triggered communication controller into sticky interrupt flags. It gates each flag with an enable and drives both individual and grouped interrupt request lines. There are 172 sources in total:

- 128 message buffers,
- two receive-FIFO watermark comparators,
- one wakeup detector,
- 25 protocol events,
- 16 host-interface errors.

The protocol events are enabled one by one. The host-interface errors all share a single enable.

Software reaches the flags, the enables and the FIFO watermarks through a small word-addressed register port. Reads are combinational. Writes take effect at the clock edge. Each flag is cleared by writing 1 to its bit. The FIFO flags are not driven by pulses: they follow a strict comparison of each FIFO's fill level against its programmed watermark, and that comparison is re-evaluated every cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags, all enables and both watermarks are 0, and every individual and grouped request output is low.
- R2: A pulse on bit n of the message-buffer event input sets message-buffer flag n, and the flag stays set after the pulse ends. Flag n reads at address n/32, bit n mod 32.
- R3: Message-buffer request n is high exactly while flag n and enable n are both set. Enable n is written at address 4 + n/32, bit n mod 32. Grouped request bit 0 is the OR of all message-buffer requests.
- R4: Writing 1 to a flag's bit at its flag address clears that flag. Writing 0 leaves the flag unchanged.
- R5: When a set condition and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R6: Address 13 holds the watermark of FIFO 0 in bits 7:0 and of FIFO 1 in bits 15:8. FIFO flag f sets only when fill level f is strictly greater than watermark f; a level equal to the watermark does not set it. The FIFO flags read at address 8, bits 0 and 1.
- R7: While a fill level stays above its watermark, clearing its flag has no effect. Once the level has dropped to the watermark or below, a clear takes effect.
- R8: The wakeup flag (address 8, bit 2) is set by a wakeup pulse. Its request, and grouped bit 2, are high only while the wakeup enable (address 9, bit 2) is set. The FIFO enables sit at address 9, bits 0 and 1, and FIFO requests feed grouped bit 1.
- R9: Protocol flags 24:0 read at address 10. Each has its own enable bit at address 11. Grouped bit 3 is the OR of the enabled protocol requests.
- R10: Host-interface error flags 15:0 read at address 12. All of their requests are gated by the single common enable at address 9, bit 3. Grouped bit 4 is the OR of those requests.
- R11: Addresses 14 and 15 read as 0, and writes to them change no flag or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_evt_i | input | 128 | Message-buffer slot-status update pulses |
| fifo_lvl_i | input | 16 | Fill levels, FIFO 0 in bits 7:0 |
| wake_evt_i | input | 1 | Wakeup symbol received pulse |
| proto_evt_i | input | 25 | Protocol event pulses |
| err_evt_i | input | 16 | Host-interface error pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mb_irq_o | output | 128 | Message-buffer requests |
| fifo_irq_o | output | 2 | FIFO almost-full requests |
| wake_irq_o | output | 1 | Wakeup request |
| proto_irq_o | output | 25 | Protocol requests |
| err_irq_o | output | 16 | Host-interface error requests |
| grp_irq_o | output | 5 | Grouped requests: 0 buffers, 1 FIFOs, 2 wakeup, 3 protocol, 4 errors |

## Verification
A source's set condition and a software write-1 clear of the same flag can land in the same cycle. The bench provokes this in two ways. First, it pulses a message-buffer event on the very clock in which it writes that buffer's clear bit. Second, it holds a FIFO level above its watermark while clearing that FIFO's flag. In both cases the flag must read back as set afterwards, and the grouped request must stay high. A later clear, issued once the set condition is gone, must then drop the flag.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int MB_N     = 128;
    localparam int FIFO_N   = 2;
    localparam int PROTO_N  = 25;
    localparam int ERR_N    = 16;
    localparam int LVL_W    = 8;
    localparam int MB_WORDS = MB_N / DATA_W;
    localparam int WM_W     = FIFO_N * LVL_W;
    localparam int SRC_N    = MB_N + FIFO_N + 1 + PROTO_N + ERR_N;
    localparam int GRP_N    = 5;

    // grouped request bit positions
    localparam int G_MB    = 0;
    localparam int G_FIFO  = 1;
    localparam int G_WAKE  = 2;
    localparam int G_PROTO = 3;
    localparam int G_ERR   = 4;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_MB_FLAG    = '0;
    localparam logic [ADDR_W-1:0] A_MB_EN      = ADDR_W'(MB_WORDS);
    localparam logic [ADDR_W-1:0] A_MISC_FLAG  = ADDR_W'(2 * MB_WORDS);
    localparam logic [ADDR_W-1:0] A_MISC_EN    = ADDR_W'(2 * MB_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_PROTO_FLAG = ADDR_W'(2 * MB_WORDS + 2);
    localparam logic [ADDR_W-1:0] A_PROTO_EN   = ADDR_W'(2 * MB_WORDS + 3);
    localparam logic [ADDR_W-1:0] A_ERR_FLAG   = ADDR_W'(2 * MB_WORDS + 4);
    localparam logic [ADDR_W-1:0] A_WMARK      = ADDR_W'(2 * MB_WORDS + 5);

    typedef struct packed {
        logic [MB_N-1:0]    mb;
        logic [FIFO_N-1:0]  fifo;
        logic               wake;
        logic [PROTO_N-1:0] proto;
        logic [ERR_N-1:0]   err;
    } src_vec_t;

    typedef struct packed {
        logic [MB_N-1:0]    mb;
        logic [FIFO_N-1:0]  fifo;
        logic               wake;
        logic [PROTO_N-1:0] proto;
        logic               err;   // one enable shared by all error sources
    } en_vec_t;

    // sticky update: a set overrides a simultaneous clear
    function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t set, src_vec_t clr);
        return set | (cur & ~clr);
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t flag_o
);
    always_ff @(posedge clk) begin
        if (rst) flag_o <= '0;
        else     flag_o <= sticky_next(flag_o, set_i, clr_i);
    end
endmodule

// File: rtl/irq_wm_cmp.sv
module irq_wm_cmp #(
    parameter int N = 2,
    parameter int W = 8
) (
    input  logic [N*W-1:0] lvl_i,
    input  logic [N*W-1:0] wm_i,
    output logic [N-1:0]   above_o
);
    for (genvar f = 0; f < N; f++) begin : g_cmp
        assign above_o[f] = lvl_i[f*W +: W] > wm_i[f*W +: W];
    end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  src_vec_t          flag_i,
    output src_vec_t          clr_o,
    output en_vec_t           en_o,
    output logic [WM_W-1:0]   wm_o,
    output logic [DATA_W-1:0] rdata_o
);
    // write-1-to-clear strobes
    always_comb begin
        clr_o = '0;
        if (wr_i) begin
            for (int k = 0; k < MB_WORDS; k++)
                if (addr_i == A_MB_FLAG + ADDR_W'(k)) clr_o.mb[k*DATA_W +: DATA_W] = wdata_i;
            case (addr_i)
                A_MISC_FLAG: begin
                    clr_o.fifo = wdata_i[FIFO_N-1:0];
                    clr_o.wake = wdata_i[FIFO_N];
                end
                A_PROTO_FLAG: clr_o.proto = wdata_i[PROTO_N-1:0];
                A_ERR_FLAG:   clr_o.err   = wdata_i[ERR_N-1:0];
                default: ;
            endcase
        end
    end

    // enables and watermarks
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= '0;
            wm_o <= '0;
        end else if (wr_i) begin
            for (int k = 0; k < MB_WORDS; k++)
                if (addr_i == A_MB_EN + ADDR_W'(k)) en_o.mb[k*DATA_W +: DATA_W] <= wdata_i;
            case (addr_i)
                A_MISC_EN: begin
                    en_o.fifo <= wdata_i[FIFO_N-1:0];
                    en_o.wake <= wdata_i[FIFO_N];
                    en_o.err  <= wdata_i[FIFO_N+1];
                end
                A_PROTO_EN: en_o.proto <= wdata_i[PROTO_N-1:0];
                A_WMARK:    wm_o       <= wdata_i[WM_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < MB_WORDS; k++) begin
            if (addr_i == A_MB_FLAG + ADDR_W'(k)) rdata_o = flag_i.mb[k*DATA_W +: DATA_W];
            if (addr_i == A_MB_EN + ADDR_W'(k))   rdata_o = en_o.mb[k*DATA_W +: DATA_W];
        end
        case (addr_i)
            A_MISC_FLAG:  rdata_o = DATA_W'({flag_i.wake, flag_i.fifo});
            A_MISC_EN:    rdata_o = DATA_W'({en_o.err, en_o.wake, en_o.fifo});
            A_PROTO_FLAG: rdata_o = DATA_W'(flag_i.proto);
            A_PROTO_EN:   rdata_o = DATA_W'(en_o.proto);
            A_ERR_FLAG:   rdata_o = DATA_W'(flag_i.err);
            A_WMARK:      rdata_o = DATA_W'(wm_o);
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [MB_N-1:0]         mb_evt_i,
    input  logic [WM_W-1:0]         fifo_lvl_i,
    input  logic                    wake_evt_i,
    input  logic [PROTO_N-1:0]      proto_evt_i,
    input  logic [ERR_N-1:0]        err_evt_i,
    input  logic                    reg_wr_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    output logic [MB_N-1:0]         mb_irq_o,
    output logic [FIFO_N-1:0]       fifo_irq_o,
    output logic                    wake_irq_o,
    output logic [PROTO_N-1:0]      proto_irq_o,
    output logic [ERR_N-1:0]        err_irq_o,
    output logic [GRP_N-1:0]        grp_irq_o
);
    src_vec_t          set_v;
    src_vec_t          clr_v;
    src_vec_t          flag_q;
    en_vec_t           en_q;
    logic [WM_W-1:0]   wm_q;
    logic [FIFO_N-1:0] fifo_above;

    irq_wm_cmp #(.N(FIFO_N), .W(LVL_W)) u_cmp (
        .lvl_i   (fifo_lvl_i),
        .wm_i    (wm_q),
        .above_o (fifo_above)
    );

    always_comb begin
        set_v.mb    = mb_evt_i;
        set_v.fifo  = fifo_above;
        set_v.wake  = wake_evt_i;
        set_v.proto = proto_evt_i;
        set_v.err   = err_evt_i;
    end

    irq_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flag_q)
    );

    irq_regif u_regif (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flag_i  (flag_q),
        .clr_o   (clr_v),
        .en_o    (en_q),
        .wm_o    (wm_q),
        .rdata_o (reg_rdata_o)
    );

    always_comb begin
        mb_irq_o    = flag_q.mb & en_q.mb;
        fifo_irq_o  = flag_q.fifo & en_q.fifo;
        wake_irq_o  = flag_q.wake & en_q.wake;
        proto_irq_o = flag_q.proto & en_q.proto;
        err_irq_o   = flag_q.err & {ERR_N{en_q.err}};
        grp_irq_o          = '0;
        grp_irq_o[G_MB]    = |mb_irq_o;
        grp_irq_o[G_FIFO]  = |fifo_irq_o;
        grp_irq_o[G_WAKE]  = wake_irq_o;
        grp_irq_o[G_PROTO] = |proto_irq_o;
        grp_irq_o[G_ERR]   = |err_irq_o;
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irqagg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SRC_N-1:0] set_v,
    input logic [SRC_N-1:0] clr_v,
    input logic [SRC_N-1:0] flag_v,
    input logic [MB_N-1:0]  en_mb,
    input logic             err_en,
    input logic [WM_W-1:0]  lvl,
    input logic [WM_W-1:0]  wm,
    input logic [GRP_N-1:0] grp_irq,
    input logic [ERR_N-1:0] err_irq
);
    localparam int FIFO_LSB = ERR_N + PROTO_N + 1;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grp_irq == '0 && flag_v == '0));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((flag_v & $past(set_v)) == $past(set_v)));

    assert_grp_mb_R3: assert property (@(posedge clk) disable iff (rst)
        grp_irq[G_MB] |-> (|(flag_v[SRC_N-1 -: MB_N] & en_mb)));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & ~set_v)) |=> ((flag_v & $past(clr_v & ~set_v)) == '0));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & set_v)) |=> ((flag_v & $past(clr_v & set_v)) == $past(clr_v & set_v)));

    for (genvar f = 0; f < FIFO_N; f++) begin : g_fifo
        assert_fifo_above_R6: assert property (@(posedge clk) disable iff (rst)
            (lvl[f*LVL_W +: LVL_W] > wm[f*LVL_W +: LVL_W]) |=> flag_v[FIFO_LSB + f]);
    end

    assert_err_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !err_en |-> (err_irq == '0));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .set_v   (set_v),
    .clr_v   (clr_v),
    .flag_v  (flag_q),
    .en_mb   (en_q.mb),
    .err_en  (en_q.err),
    .lvl     (fifo_lvl_i),
    .wm      (wm_q),
    .grp_irq (grp_irq_o),
    .err_irq (err_irq_o)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    logic         clk = 0;
    logic         rst = 1;
    logic [127:0] mb_evt = '0;
    logic [15:0]  lvl = '0;
    logic         wake_evt = 0;
    logic [24:0]  proto_evt = '0;
    logic [15:0]  err_evt = '0;
    logic         wr = 0;
    logic [3:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] mb_irq;
    logic [1:0]   fifo_irq;
    logic         wake_irq;
    logic [24:0]  proto_irq;
    logic [15:0]  err_irq;
    logic [4:0]   grp_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .mb_evt_i(mb_evt), .fifo_lvl_i(lvl),
        .wake_evt_i(wake_evt), .proto_evt_i(proto_evt), .err_evt_i(err_evt),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .mb_irq_o(mb_irq), .fifo_irq_o(fifo_irq), .wake_irq_o(wake_irq),
        .proto_irq_o(proto_irq), .err_irq_o(err_irq), .grp_irq_o(grp_irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp_rd;
        logic [4:0]  exp_grp;
        int          ind_sel;
        logic [31:0] exp_ind;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] ind;
                it = sb_q.pop_front();
                case (it.ind_sel)
                    1:       ind = mb_irq[31:0];
                    2:       ind = {29'b0, wake_irq, fifo_irq};
                    3:       ind = {7'b0, proto_irq};
                    4:       ind = {16'b0, err_irq};
                    default: ind = '0;
                endcase
                checks++;
                if (rdata !== it.exp_rd || grp_irq !== it.exp_grp ||
                    (it.ind_sel != 0 && ind !== it.exp_ind)) begin
                    errors++;
                    $display("FAIL %s: rdata=%h grp=%b ind=%h expected rdata=%h grp=%b ind=%h",
                             it.tag, rdata, grp_irq, ind, it.exp_rd, it.exp_grp, it.exp_ind);
                end
            end
        end
    end

    // driver tasks
    task automatic chk(string tag, logic [3:0] a, logic [31:0] exp_rd, logic [4:0] exp_grp,
                       int ind_sel = 0, logic [31:0] exp_ind = '0);
        item_t it;
        @(negedge clk);
        addr = a;
        it.tag = tag; it.exp_rd = exp_rd; it.exp_grp = exp_grp;
        it.ind_sel = ind_sel; it.exp_ind = exp_ind;
        sb_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic wr_reg(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0; wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 mb flags", 4'd0, 32'h0, 5'b0, 1, 32'h0);
        chk("R1 misc enables", 4'd9, 32'h0, 5'b0);
        chk("R1 watermarks", 4'd13, 32'h0, 5'b0);

        // R2: sticky message-buffer flags, word/bit mapping
        @(negedge clk); mb_evt[3] = 1; mb_evt[40] = 1;
        @(negedge clk); mb_evt = '0;
        idle(2);
        chk("R2 word0 flag", 4'd0, 32'h8, 5'b0, 1, 32'h0);
        chk("R2 word1 flag", 4'd1, 32'h100, 5'b0);

        // R3: enable gates request and group bit 0
        wr_reg(4'd4, 32'h8);
        chk("R3 enabled mb req", 4'd4, 32'h8, 5'b00001, 1, 32'h8);

        // R4: write 0 no effect, write 1 clears
        wr_reg(4'd0, 32'h0);
        chk("R4 write0 keeps", 4'd0, 32'h8, 5'b00001);
        wr_reg(4'd1, 32'h100);
        chk("R4 word1 cleared", 4'd1, 32'h0, 5'b00001);
        wr_reg(4'd0, 32'h8);
        chk("R4 word0 cleared", 4'd0, 32'h0, 5'b0, 1, 32'h0);

        // R5: set and clear in the same cycle
        @(negedge clk); mb_evt[3] = 1; wr = 1; addr = 4'd0; wdata = 32'h8;
        @(negedge clk); mb_evt = '0; wr = 0; wdata = '0;
        chk("R5 set wins", 4'd0, 32'h8, 5'b00001, 1, 32'h8);
        wr_reg(4'd0, 32'h8);
        chk("R5 later clear", 4'd0, 32'h0, 5'b0);

        // R6: strict watermark compare
        wr_reg(4'd13, 32'h6432);
        chk("R6 watermark readback", 4'd13, 32'h6432, 5'b0);
        @(negedge clk); lvl = {8'd100, 8'd50};
        idle(2);
        chk("R6 equal level no flag", 4'd8, 32'h0, 5'b0);
        @(negedge clk); lvl = {8'd100, 8'd51};
        idle(2);
        chk("R6 above sets fifo0", 4'd8, 32'h1, 5'b0, 2, 32'h0);
        wr_reg(4'd9, 32'h1);
        chk("R8 fifo enable group", 4'd8, 32'h1, 5'b00010, 2, 32'h1);

        // R7: clear ignored while level above
        wr_reg(4'd8, 32'h1);
        chk("R7 clear while above", 4'd8, 32'h1, 5'b00010, 2, 32'h1);
        @(negedge clk); lvl = {8'd101, 8'd0};
        idle(2);
        wr_reg(4'd8, 32'h1);
        chk("R7 clear after drop / fifo1 set", 4'd8, 32'h2, 5'b0, 2, 32'h0);
        @(negedge clk); lvl = '0;
        idle(1);
        wr_reg(4'd8, 32'h2);
        chk("R7 fifo1 cleared", 4'd8, 32'h0, 5'b0);

        // R8: wakeup
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        chk("R8 wake flag no enable", 4'd8, 32'h4, 5'b0, 2, 32'h0);
        wr_reg(4'd9, 32'h5);
        chk("R8 wake enabled", 4'd9, 32'h5, 5'b00100, 2, 32'h4);
        wr_reg(4'd8, 32'h4);
        chk("R8 wake cleared", 4'd8, 32'h0, 5'b0);

        // R9: protocol sources with individual enables
        @(negedge clk); proto_evt[0] = 1; proto_evt[24] = 1;
        @(negedge clk); proto_evt = '0;
        chk("R9 proto flags", 4'd10, 32'h0100_0001, 5'b0, 3, 32'h0);
        wr_reg(4'd11, 32'h0100_0000);
        chk("R9 one proto enabled", 4'd11, 32'h0100_0000, 5'b01000, 3, 32'h0100_0000);
        wr_reg(4'd10, 32'h0100_0001);
        chk("R9 proto cleared", 4'd10, 32'h0, 5'b0, 3, 32'h0);

        // R10: shared error enable
        @(negedge clk); err_evt[2] = 1; err_evt[15] = 1;
        @(negedge clk); err_evt = '0;
        chk("R10 err flags gated", 4'd12, 32'h8004, 5'b0, 4, 32'h0);
        wr_reg(4'd9, 32'hD);
        chk("R10 common enable on", 4'd12, 32'h8004, 5'b10000, 4, 32'h8004);
        wr_reg(4'd9, 32'h5);
        chk("R10 common enable off", 4'd12, 32'h8004, 5'b0, 4, 32'h0);
        wr_reg(4'd12, 32'h8004);
        chk("R10 err cleared", 4'd12, 32'h0, 5'b0);

        // R11: unused addresses
        @(negedge clk); mb_evt[127] = 1;
        @(negedge clk); mb_evt = '0;
        wr_reg(4'd14, 32'hFFFF_FFFF);
        wr_reg(4'd15, 32'hFFFF_FFFF);
        chk("R11 addr14 reads zero", 4'd14, 32'h0, 5'b0);
        chk("R11 addr15 reads zero", 4'd15, 32'h0, 5'b0);
        chk("R11 flag untouched", 4'd3, 32'h8000_0000, 5'b0);
        chk("R11 enables untouched", 4'd9, 32'h5, 5'b0);
        wr_reg(4'd7, 32'h8000_0000);
        chk("R3 top buffer enabled", 4'd7, 32'h8000_0000, 5'b00001);

        idle(2);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule